// File: doc/BRIEF.md
# Four-Bit Indirect Status Bus Interface

This block is the host-facing control port of a four-channel line feed controller. A processor reaches it over a four-bit data bus, split here into write data, read data and an output-enable. The bus also carries one address bit, an address strobe that can hold the address bit, an active-low select, and active-low read and write strobes. Two locations are visible. The control location holds a three-bit group selector and an interrupt-enable bit. The request location holds one on/off request bit per channel. Status is read indirectly: the selector picks which set of four per-channel bits appears when the request location is read.

Requests pass to the line drivers only on channels whose thermal trip flag permits it. A per-channel persistence filter turns a raw current-limit indication into an overload flag, and only a sustained limit sets that flag. An active-low interrupt reports any overload while interrupts are enabled. A parallel mode takes the bus out of use. In that mode per-channel request pins drive the lines directly, and a per-channel status pin combines the fault sources.

Bus accesses are sequenced by a small state machine with three states. ST_IDLE waits for the select. The transition IDLE→WR_HOLD is taken when select and write are both low, and the write is committed on that edge. The transition IDLE→RD is taken when select and read are both low. WR_HOLD→IDLE is taken once the write strobe or the select rises. RD→IDLE is taken once the read strobe or the select rises. In parallel mode the machine stays in ST_IDLE.

Top module: `lfc_status_bus`

## Requirements
- R1: After reset the selector is 000, interrupt enable is 0, all request and drive bits are 0, `irq_n` is 1 and `bus_oe` is 0.
- R2: `bus_oe` is 1 only while `par_mode` is 0, `bus_sel_n` is 0 and `bus_rd_n` is 0. At all other times the read data is not driven.
- R3: While `bus_addr_strobe` is 1 the effective address follows `bus_addr`. While it is 0 the effective address is the value of `bus_addr` at the last clock edge at which the strobe was 1.
- R4: A write to address 0 loads `bus_wdata[2:0]` into the selector and `bus_wdata[3]` into interrupt enable. A read of address 0 returns the selector on bits 2..0 and `over_temp` on bit 3.
- R5: A write to address 1 loads the request bits, with bit n controlling channel n.
- R6: One clock edge after any change, each drive bit (and `line_on` in bus mode) equals the request bit AND `trip_ok` for that channel.
- R7: A read of address 1 returns the group chosen by the selector. The codes are: 000 power-up status, 001 open-loop flags, 010 overload flags, 011 drive bits, 110 request bits, 111 trip flags. The reserved codes 100 and 101 return 0000.
- R8: A channel's overload flag becomes 1 after `cur_lim` has been sampled 1 on HOLD_CYCLES consecutive edges. A single sample of 0 clears both the flag and its count on the next edge.
- R9: One edge after the overload flags change, `irq_n` is 0 exactly when interrupt enable is 1 and any overload flag is 1 in bus mode; otherwise it is 1.
- R10: A write strobe held low across many edges commits once, using the data present on its first edge. Later data changes are ignored.
- R11: With `par_mode` = 1, bus writes are ignored. `line_on` equals `par_req` AND `trip_ok`, and `par_stat` equals `par_req` AND (overload OR `pwr_up` OR NOT `trip_ok`). `par_stat` is 0 in bus mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| par_mode | input | 1 | 1 selects parallel mode, 0 selects bus mode |
| bus_addr_strobe | input | 1 | Address hold strobe: transparent when 1 |
| bus_addr | input | 1 | Address bit |
| bus_sel_n | input | 1 | Active-low select |
| bus_rd_n | input | 1 | Active-low read strobe |
| bus_wr_n | input | 1 | Active-low write strobe |
| bus_wdata | input | NCH | Write data |
| bus_rdata | output | NCH | Read data |
| bus_oe | output | 1 | Read data drive enable |
| cur_lim | input | NCH | Raw per-channel current-limit indication |
| open_det | input | NCH | Per-channel open-loop flag |
| pwr_up | input | NCH | Per-channel power-up phase flag |
| trip_ok | input | NCH | Per-channel thermal trip permit (1 = may drive) |
| over_temp | input | 1 | Device over-temperature status |
| par_req | input | NCH | Parallel-mode per-channel requests |
| par_stat | output | NCH | Parallel-mode per-channel status |
| line_on | output | NCH | Per-channel line driver enable |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Two functions can act on the same clock edge. One is a write that sets interrupt enable; the other is the persistence counter reaching its terminal count. The bench aligns them by raising `cur_lim` and timing a write to the control location so that it commits on exactly the edge where the overload flag rises. It then expects `irq_n` to be still 1 before the next edge and 0 after it. A second overlap is a request write committing while the trip flags change. Here the drive bits must reflect both on the following edge.

// File: rtl/lfc_bus_pkg.sv
package lfc_bus_pkg;

    localparam int SEL_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WR_HOLD = 2'd1,
        ST_RD      = 2'd2
    } bus_state_e;

    typedef enum logic [SEL_W-1:0] {
        GRP_PWRUP = 3'b000,
        GRP_OPEN  = 3'b001,
        GRP_OVL   = 3'b010,
        GRP_DRIVE = 3'b011,
        GRP_RSV4  = 3'b100,
        GRP_RSV5  = 3'b101,
        GRP_REQ   = 3'b110,
        GRP_TRIP  = 3'b111
    } grp_e;

endpackage

// File: rtl/lfc_addr_latch.sv
module lfc_addr_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic addr_in,
    output logic addr_eff
);
    logic held_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= 1'b0;
        end else if (strobe) begin
            held_q <= addr_in;
        end
    end

    // transparent while the strobe is high, holds the last sampled value otherwise
    assign addr_eff = strobe ? addr_in : held_q;

endmodule

// File: rtl/lfc_persist_filter.sv
module lfc_persist_filter #(
    parameter int HOLD_CYCLES = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic flag
);
    localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
    localparam logic [CNT_W-1:0] TERM = CNT_W'(HOLD_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!raw) begin
            cnt_q <= '0;
        end else if (cnt_q != TERM) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign flag = (cnt_q == TERM);

    // R8: the flag can only be high if the raw level was high on the last edge
    assert_flag_needs_level_R8: assert property (
        @(posedge clk) disable iff (!rst_n) flag |-> $past(raw)
    );

endmodule

// File: rtl/lfc_bus_ctrl.sv
module lfc_bus_ctrl
    import lfc_bus_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             sel_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic             addr,
    input  logic [NCH-1:0]   wdata,
    input  logic [NCH-1:0]   trip_ok,
    output logic [SEL_W-1:0] sel_code,
    output logic             irq_en,
    output logic [NCH-1:0]   req_q,
    output logic [NCH-1:0]   drive_q,
    output logic             data_oe
);
    localparam int IEN_BIT = SEL_W;

    bus_state_e state_q, state_d;
    logic       wr_fire;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (enable && !sel_n && !wr_n) begin
                    state_d = ST_WR_HOLD;
                end else if (enable && !sel_n && !rd_n) begin
                    state_d = ST_RD;
                end
            end
            ST_WR_HOLD: begin
                if (sel_n || wr_n) state_d = ST_IDLE;
            end
            ST_RD: begin
                if (sel_n || rd_n) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign wr_fire = (state_q == ST_IDLE) && (state_d == ST_WR_HOLD);
    assign data_oe = enable && !sel_n && !rd_n;

    // outputs: registers updated on the committing edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_code <= '0;
            irq_en   <= 1'b0;
            req_q    <= '0;
            drive_q  <= '0;
        end else begin
            if (wr_fire && !addr) begin
                sel_code <= wdata[SEL_W-1:0];
                irq_en   <= wdata[IEN_BIT];
            end
            if (wr_fire && addr) begin
                req_q <= wdata;
            end
            drive_q <= req_q & trip_ok;
        end
    end

    // R10: a held write strobe commits nothing further
    assert_single_commit_R10: assert property (
        @(posedge clk) disable iff (!rst_n)
        (state_q == ST_WR_HOLD && !sel_n && !wr_n) |=> ($stable(req_q) && $stable(sel_code) && $stable(irq_en))
    );

    // R6: no drive bit without the trip permit on the previous edge
    assert_drive_needs_trip_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        1'b1 |-> ((drive_q & ~$past(trip_ok)) == '0)
    );

endmodule

// File: rtl/lfc_status_mux.sv
module lfc_status_mux
    import lfc_bus_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic             addr,
    input  logic [SEL_W-1:0] sel_code,
    input  logic             over_temp,
    input  logic [NCH-1:0]   grp_pwrup,
    input  logic [NCH-1:0]   grp_open,
    input  logic [NCH-1:0]   grp_ovl,
    input  logic [NCH-1:0]   grp_drive,
    input  logic [NCH-1:0]   grp_req,
    input  logic [NCH-1:0]   grp_trip,
    output logic [NCH-1:0]   rdata
);
    logic [NCH-1:0] grp_word;

    always_comb begin
        unique case (grp_e'(sel_code))
            GRP_PWRUP: grp_word = grp_pwrup;
            GRP_OPEN:  grp_word = grp_open;
            GRP_OVL:   grp_word = grp_ovl;
            GRP_DRIVE: grp_word = grp_drive;
            GRP_REQ:   grp_word = grp_req;
            GRP_TRIP:  grp_word = grp_trip;
            default:   grp_word = '0;
        endcase
    end

    always_comb begin
        if (addr) begin
            rdata = grp_word;
        end else begin
            rdata = '0;
            rdata[SEL_W-1:0] = sel_code;
            rdata[SEL_W]     = over_temp;
        end
    end

endmodule

// File: rtl/lfc_status_bus.sv
module lfc_status_bus
    import lfc_bus_pkg::*;
#(
    parameter int NCH         = 4,
    parameter int HOLD_CYCLES = 20000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           par_mode,
    input  logic           bus_addr_strobe,
    input  logic           bus_addr,
    input  logic           bus_sel_n,
    input  logic           bus_rd_n,
    input  logic           bus_wr_n,
    input  logic [NCH-1:0] bus_wdata,
    output logic [NCH-1:0] bus_rdata,
    output logic           bus_oe,
    input  logic [NCH-1:0] cur_lim,
    input  logic [NCH-1:0] open_det,
    input  logic [NCH-1:0] pwr_up,
    input  logic [NCH-1:0] trip_ok,
    input  logic           over_temp,
    input  logic [NCH-1:0] par_req,
    output logic [NCH-1:0] par_stat,
    output logic [NCH-1:0] line_on,
    output logic           irq_n
);
    logic             addr_eff;
    logic [SEL_W-1:0] sel_code;
    logic             irq_en;
    logic [NCH-1:0]   req_q;
    logic [NCH-1:0]   drive_q;
    logic [NCH-1:0]   ovl;
    logic             irq_q;

    lfc_addr_latch u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (bus_addr_strobe),
        .addr_in  (bus_addr),
        .addr_eff (addr_eff)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_filt
        lfc_persist_filter #(.HOLD_CYCLES(HOLD_CYCLES)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (cur_lim[ch]),
            .flag  (ovl[ch])
        );
    end

    lfc_bus_ctrl #(.NCH(NCH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (!par_mode),
        .sel_n    (bus_sel_n),
        .rd_n     (bus_rd_n),
        .wr_n     (bus_wr_n),
        .addr     (addr_eff),
        .wdata    (bus_wdata),
        .trip_ok  (trip_ok),
        .sel_code (sel_code),
        .irq_en   (irq_en),
        .req_q    (req_q),
        .drive_q  (drive_q),
        .data_oe  (bus_oe)
    );

    lfc_status_mux #(.NCH(NCH)) u_mux (
        .addr      (addr_eff),
        .sel_code  (sel_code),
        .over_temp (over_temp),
        .grp_pwrup (pwr_up),
        .grp_open  (open_det),
        .grp_ovl   (ovl),
        .grp_drive (drive_q),
        .grp_req   (req_q),
        .grp_trip  (trip_ok),
        .rdata     (bus_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= !par_mode && irq_en && (|ovl);
        end
    end

    assign irq_n    = !irq_q;
    assign line_on  = par_mode ? (par_req & trip_ok) : drive_q;
    assign par_stat = par_mode ? (par_req & (ovl | pwr_up | ~trip_ok)) : '0;

    // R9: interrupt only follows an enable seen on the previous edge
    assert_irq_enabled_R9: assert property (
        @(posedge clk) disable iff (!rst_n) !irq_n |-> $past(irq_en)
    );

    // R2: parallel mode never drives the read data
    assert_bus_quiet_R2: assert property (
        @(posedge clk) disable iff (!rst_n) par_mode |-> !bus_oe
    );

endmodule

// File: tb/lfc_status_bus_tb.sv
module lfc_status_bus_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 4;
    localparam int HOLD       = 5;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           par_mode = 1'b0;
    logic           bus_addr_strobe = 1'b1;
    logic           bus_addr = 1'b0;
    logic           bus_sel_n = 1'b1;
    logic           bus_rd_n = 1'b1;
    logic           bus_wr_n = 1'b1;
    logic [NCH-1:0] bus_wdata = '0;
    logic [NCH-1:0] bus_rdata;
    logic           bus_oe;
    logic [NCH-1:0] cur_lim = '0;
    logic [NCH-1:0] open_det = '0;
    logic [NCH-1:0] pwr_up = '0;
    logic [NCH-1:0] trip_ok = '1;
    logic           over_temp = 1'b0;
    logic [NCH-1:0] par_req = '0;
    logic [NCH-1:0] par_stat;
    logic [NCH-1:0] line_on;
    logic           irq_n;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lfc_status_bus #(.NCH(NCH), .HOLD_CYCLES(HOLD)) u_dut (
        .clk(clk), .rst_n(rst_n), .par_mode(par_mode),
        .bus_addr_strobe(bus_addr_strobe), .bus_addr(bus_addr),
        .bus_sel_n(bus_sel_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_oe(bus_oe),
        .cur_lim(cur_lim), .open_det(open_det), .pwr_up(pwr_up),
        .trip_ok(trip_ok), .over_temp(over_temp), .par_req(par_req),
        .par_stat(par_stat), .line_on(line_on), .irq_n(irq_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // commit on the next edge, release on the following falling edge
    task automatic bus_write_here(input logic [NCH-1:0] d);
        @(negedge clk);
        bus_wdata = d; bus_sel_n = 1'b0; bus_wr_n = 1'b0;
        @(negedge clk);
        bus_sel_n = 1'b1; bus_wr_n = 1'b1;
    endtask

    task automatic bus_write(input logic a, input logic [NCH-1:0] d);
        bus_addr = a;
        bus_write_here(d);
    endtask

    // combinational read at the current time, no edge consumed
    task automatic bus_read(input logic a, output logic [NCH-1:0] d, output logic oe);
        bus_addr = a; bus_sel_n = 1'b0; bus_rd_n = 1'b0;
        #1;
        d = bus_rdata; oe = bus_oe;
        bus_sel_n = 1'b1; bus_rd_n = 1'b1;
        #1;
    endtask

    task automatic t_reset();
        logic [NCH-1:0] d; logic oe;
        @(negedge clk);
        check("R1 irq_n", {7'd0, irq_n}, 8'd1);
        check("R1 line_on", {4'd0, line_on}, 8'd0);
        check("R1 idle oe", {7'd0, bus_oe}, 8'd0);
        bus_read(1'b0, d, oe);
        check("R1 ctrl word", {4'd0, d}, 8'd0);
        check("R2 oe on read", {7'd0, oe}, 8'd1);
        bus_write(1'b0, 4'b0110);
        bus_read(1'b1, d, oe);
        check("R1 request zero", {4'd0, d}, 8'd0);
    endtask

    task automatic t_ctrl_reg();
        logic [NCH-1:0] d; logic oe;
        bus_write(1'b0, 4'b0101);
        over_temp = 1'b1;
        bus_read(1'b0, d, oe);
        check("R4 sel + over_temp", {4'd0, d}, 8'h0D);
        over_temp = 1'b0;
        bus_read(1'b0, d, oe);
        check("R4 sel no over_temp", {4'd0, d}, 8'h05);
    endtask

    task automatic t_request();
        logic [NCH-1:0] d; logic oe;
        bus_write(1'b0, 4'b0110);
        bus_write(1'b1, 4'b1001);
        bus_read(1'b1, d, oe);
        check("R5 request bits", {4'd0, d}, 8'h09);
        bus_write(1'b0, 4'b0011);
        bus_write(1'b1, 4'b0101);
        bus_read(1'b1, d, oe);
        check("R6 drive lags one edge", {4'd0, d}, 8'h09);
        @(negedge clk);
        bus_read(1'b1, d, oe);
        check("R6 drive bits", {4'd0, d}, 8'h05);
        check("R6 line_on", {4'd0, line_on}, 8'h05);
        trip_ok = 4'b1011;
        @(negedge clk);
        check("R6 trip masks drive", {4'd0, line_on}, 8'h01);
        trip_ok = 4'b1111;
        @(negedge clk);
    endtask

    task automatic t_groups();
        logic [NCH-1:0] d; logic oe;
        pwr_up = 4'b1010; open_det = 4'b0110; trip_ok = 4'b1101;
        bus_write(1'b0, 4'b0000);
        bus_read(1'b1, d, oe);
        check("R7 code 000 pwr_up", {4'd0, d}, 8'h0A);
        bus_write(1'b0, 4'b0001);
        bus_read(1'b1, d, oe);
        check("R7 code 001 open", {4'd0, d}, 8'h06);
        bus_write(1'b0, 4'b0111);
        bus_read(1'b1, d, oe);
        check("R7 code 111 trip", {4'd0, d}, 8'h0D);
        pwr_up = '1; open_det = '1; trip_ok = '1;
        bus_write(1'b0, 4'b0100);
        bus_read(1'b1, d, oe);
        check("R7 code 100 reserved", {4'd0, d}, 8'h00);
        bus_write(1'b0, 4'b0101);
        bus_read(1'b1, d, oe);
        check("R7 code 101 reserved", {4'd0, d}, 8'h00);
        pwr_up = '0; open_det = '0;
    endtask

    task automatic t_addr_latch();
        logic [NCH-1:0] d; logic oe;
        bus_write(1'b0, 4'b0110);
        @(negedge clk);
        bus_addr = 1'b1;
        @(negedge clk);
        bus_addr_strobe = 1'b0; bus_addr = 1'b0;
        bus_write_here(4'b0011);
        bus_addr_strobe = 1'b1;
        bus_read(1'b1, d, oe);
        check("R3 held address 1 hit request", {4'd0, d}, 8'h03);
        bus_read(1'b0, d, oe);
        check("R3 control untouched", {4'd0, d}, 8'h06);
    endtask

    task automatic t_one_shot();
        logic [NCH-1:0] d; logic oe;
        bus_write(1'b0, 4'b0110);
        bus_addr = 1'b1;
        @(negedge clk);
        bus_wdata = 4'b0011; bus_sel_n = 1'b0; bus_wr_n = 1'b0;
        @(negedge clk);
        bus_wdata = 4'b1100;
        repeat (3) @(negedge clk);
        bus_sel_n = 1'b1; bus_wr_n = 1'b1;
        bus_read(1'b1, d, oe);
        check("R10 held strobe commits once", {4'd0, d}, 8'h03);
    endtask

    task automatic t_persist();
        logic [NCH-1:0] d; logic oe;
        bus_write(1'b0, 4'b0010);
        @(negedge clk);
        cur_lim = 4'b0001;
        repeat (3) @(negedge clk);
        cur_lim = 4'b0000;
        @(negedge clk);
        cur_lim = 4'b0001;
        repeat (4) @(negedge clk);
        bus_read(1'b1, d, oe);
        check("R8 gap restarts count", {4'd0, d}, 8'h00);
        @(negedge clk);
        bus_read(1'b1, d, oe);
        check("R8 flag after HOLD edges", {4'd0, d}, 8'h01);
        check("R9 irq stays off when disabled", {7'd0, irq_n}, 8'd1);
        cur_lim = 4'b0000;
        @(negedge clk);
        bus_read(1'b1, d, oe);
        check("R8 flag clears", {4'd0, d}, 8'h00);
    endtask

    task automatic t_irq();
        bus_write(1'b0, 4'b1010);
        cur_lim = 4'b0100;
        repeat (5) @(negedge clk);
        check("R9 irq not yet", {7'd0, irq_n}, 8'd1);
        @(negedge clk);
        check("R9 irq asserted", {7'd0, irq_n}, 8'd0);
        cur_lim = 4'b0000;
        @(negedge clk);
        check("R9 irq still low", {7'd0, irq_n}, 8'd0);
        @(negedge clk);
        check("R9 irq released", {7'd0, irq_n}, 8'd1);
    endtask

    task automatic t_collide();
        bus_write(1'b0, 4'b0010);
        @(negedge clk);
        cur_lim = 4'b0010;
        repeat (3) @(negedge clk);
        bus_write(1'b0, 4'b1010);
        check("R9 collide edge irq high", {7'd0, irq_n}, 8'd1);
        @(negedge clk);
        check("R9 collide next edge irq low", {7'd0, irq_n}, 8'd0);
        cur_lim = 4'b0000;
        repeat (2) @(negedge clk);
        bus_write(1'b0, 4'b0010);
    endtask

    task automatic t_parallel();
        logic [NCH-1:0] d; logic oe;
        bus_write(1'b0, 4'b0110);
        @(negedge clk);
        par_mode = 1'b1; par_req = 4'b0011; trip_ok = 4'b1110; pwr_up = 4'b0000;
        #1;
        check("R11 par_stat", {4'd0, par_stat}, 8'h01);
        check("R11 line_on", {4'd0, line_on}, 8'h02);
        pwr_up = 4'b0010;
        #1;
        check("R11 par_stat pwr_up", {4'd0, par_stat}, 8'h03);
        bus_read(1'b0, d, oe);
        check("R2 no drive in parallel", {7'd0, oe}, 8'd0);
        bus_write(1'b0, 4'b0001);
        @(negedge clk);
        par_mode = 1'b0; trip_ok = '1; pwr_up = '0; par_req = '0;
        #1;
        check("R11 par_stat zero in bus mode", {4'd0, par_stat}, 8'h00);
        bus_read(1'b0, d, oe);
        check("R11 write ignored", {4'd0, d}, 8'h06);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctrl_reg();
        t_request();
        t_groups();
        t_addr_latch();
        t_one_shot();
        t_persist();
        t_irq();
        t_collide();
        t_parallel();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule